// File: doc/BRIEF.md
# Self-Test Address Sequencer

This block produces the stream of DRAM addresses that a memory self-test pass walks through. It has no data path. A command issuer downstream takes one (bank, row, column) address per handshake and turns it into DRAM commands. The data checker also sits outside this block. Each pass is set up when `go_i` is pulsed, and it uses the configuration sampled in that cycle:

- an ordering mode that says which address dimension moves fastest;
- a direction, counting up or down;
- a choice between the whole array and a box bounded by a start address and an end address;
- a one-hot rank choice, held on its own output for the whole pass.

Addresses leave through a valid/ready stream. When `addr_valid_o` is high and `addr_ready_i` is low, the address and last flag hold steady until a beat is accepted. `addr_ready_i` may stay low for any number of cycles. The final address of the pass carries `addr_last_o`. Once that beat is accepted the stream goes idle. A `restart_i` pulse reloads the first address of the stored configuration, so a read-and-compare pass can follow a write pass over the same addresses.

Top module: `bist_addr_seq`

## Requirements
- R1: After reset, `addr_valid_o`, `addr_last_o` and `busy_o` are low.
- R2: A `go_i` pulse while idle samples the configuration inputs. `addr_valid_o` rises on the next cycle, carrying the first address of the pass.
- R3: Mode 2'b00 steps the column fastest, then the row on each column wrap, then the bank on each row wrap.
- R4: Mode 2'b01 steps the row fastest, then the column on each row wrap, then the bank.
- R5: Mode 2'b10 behaves as follows. Row and column both step on every beat, and each wraps to its own first value independently. The bank steps when the column wraps. The pass ends when column and bank are both at their final values.
- R6: Mode 2'b11 steps the column fastest, then the bank on each column wrap, then the row on each bank wrap.
- R7: With `down_i` high, every dimension starts at its upper bound and counts down to its lower bound. With `down_i` low, it counts up.
- R8: Addresses are packed as {bank[6:5], row[4:3], col[2:0]} at default widths. With `range_en_i` high, each field stays between the corresponding fields of `start_addr_i` and `end_addr_i`. With it low, each field spans its full range.
- R9: `addr_last_o` is high exactly with the final address of the pass. After that beat is accepted, `addr_valid_o` and `busy_o` fall.
- R10: While `addr_valid_o` is high and `addr_ready_i` is low, the address and the last flag do not change.
- R11: `restart_i` reloads the first address of the stored configuration on the next cycle, both mid-pass and when idle.
- R12: In range mode, if any end field is below its start field, only the start address is emitted, and it carries `addr_last_o`.
- R13: `rank_cs_o` shows the `rank_sel_i` value sampled at `go_i` for the whole pass. A `go_i` pulse or changed configuration inputs while busy have no effect on the sequence or on `rank_cs_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Start a pass with the present configuration (ignored while busy) |
| restart_i | input | 1 | Reload the first address of the stored configuration |
| mode_i | input | 2 | Ordering: 00 col-row-bank, 01 row-col-bank, 10 row+col diagonal then bank, 11 col-bank-row |
| down_i | input | 1 | 1 counts down, 0 counts up |
| range_en_i | input | 1 | 1 bounds the sweep to start/end fields, 0 sweeps the full array |
| rank_sel_i | input | 2 | One-hot rank choice (01 rank 0, 10 rank 1) |
| start_addr_i | input | BANK_W+ROW_W+COL_W | Lower corner {bank,row,col} |
| end_addr_i | input | BANK_W+ROW_W+COL_W | Upper corner {bank,row,col} |
| addr_ready_i | input | 1 | Consumer accepts the current address |
| addr_valid_o | output | 1 | An address is offered |
| addr_bank_o | output | BANK_W | Bank of the offered address |
| addr_row_o | output | ROW_W | Row of the offered address |
| addr_col_o | output | COL_W | Column of the offered address |
| addr_last_o | output | 1 | Offered address is the final one of the pass |
| rank_cs_o | output | 2 | Rank select held for the pass |
| busy_o | output | 1 | A pass is in progress |

## Verification
A wrong counter value or a wrong carry shows up at the ports as a wrong address on the very beat after the faulty step. It appears no later than the next wrap of the affected dimension. Because of this, every accepted beat of every pass is compared with an address computed from its beat index. A stuck or early final-value decode shows as `addr_last_o` on the wrong beat, or as the stream ending early or running past its length. The bench also checks how many beats each pass has. A configuration that was latched wrongly shows on the first beat, or on `rank_cs_o` throughout the pass.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  typedef enum logic [1:0] {
    ORD_FAST_X  = 2'b00,
    ORD_FAST_Y  = 2'b01,
    ORD_FAST_XY = 2'b10,
    ORD_XZY     = 2'b11
  } ord_e;

  localparam int DIM_COL  = 0;
  localparam int DIM_ROW  = 1;
  localparam int DIM_BANK = 2;
  localparam int NUM_DIM  = 3;
endpackage

// File: rtl/bist_dim_cnt.sv
// One address dimension: wrapping up/down counter between two bounds.
module bist_dim_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         down_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] val_o,
  output logic         final_o
);
  logic [W-1:0] first_v;
  logic [W-1:0] end_v;

  assign first_v = down_i ? hi_i : lo_i;
  assign end_v   = down_i ? lo_i : hi_i;
  assign final_o = (val_o == end_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_o <= '0;
    end else if (load_i) begin
      val_o <= first_v;
    end else if (step_i) begin
      if (final_o)     val_o <= first_v;
      else if (down_i) val_o <= val_o - W'(1);
      else             val_o <= val_o + W'(1);
    end
  end
endmodule

// File: rtl/bist_step_plan.sv
// Carry network: which dimensions step on an accepted beat, and when the pass ends.
module bist_step_plan
  import bist_seq_pkg::*;
(
  input  ord_e               mode_i,
  input  logic               adv_i,
  input  logic [NUM_DIM-1:0] fin_i,
  output logic [NUM_DIM-1:0] step_o,
  output logic               last_o
);
  always_comb begin
    step_o = '0;
    last_o = 1'b0;
    case (mode_i)
      ORD_FAST_X: begin
        step_o[DIM_COL]  = adv_i;
        step_o[DIM_ROW]  = adv_i & fin_i[DIM_COL];
        step_o[DIM_BANK] = adv_i & fin_i[DIM_COL] & fin_i[DIM_ROW];
        last_o           = &fin_i;
      end
      ORD_FAST_Y: begin
        step_o[DIM_ROW]  = adv_i;
        step_o[DIM_COL]  = adv_i & fin_i[DIM_ROW];
        step_o[DIM_BANK] = adv_i & fin_i[DIM_ROW] & fin_i[DIM_COL];
        last_o           = &fin_i;
      end
      ORD_FAST_XY: begin
        step_o[DIM_COL]  = adv_i;
        step_o[DIM_ROW]  = adv_i;
        step_o[DIM_BANK] = adv_i & fin_i[DIM_COL];
        last_o           = fin_i[DIM_COL] & fin_i[DIM_BANK];
      end
      ORD_XZY: begin
        step_o[DIM_COL]  = adv_i;
        step_o[DIM_BANK] = adv_i & fin_i[DIM_COL];
        step_o[DIM_ROW]  = adv_i & fin_i[DIM_COL] & fin_i[DIM_BANK];
        last_o           = &fin_i;
      end
      default: begin
        step_o = '0;
        last_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bist_addr_seq.sv
module bist_addr_seq
  import bist_seq_pkg::*;
#(
  parameter int COL_W  = 3,
  parameter int ROW_W  = 2,
  parameter int BANK_W = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            go_i,
  input  logic                            restart_i,
  input  logic [1:0]                      mode_i,
  input  logic                            down_i,
  input  logic                            range_en_i,
  input  logic [1:0]                      rank_sel_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   start_addr_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   end_addr_i,
  input  logic                            addr_ready_i,
  output logic                            addr_valid_o,
  output logic [BANK_W-1:0]               addr_bank_o,
  output logic [ROW_W-1:0]                addr_row_o,
  output logic [COL_W-1:0]                addr_col_o,
  output logic                            addr_last_o,
  output logic [1:0]                      rank_cs_o,
  output logic                            busy_o
);
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;

  // configuration captured at go
  logic [1:0]        cfg_mode;
  logic              cfg_down;
  logic              cfg_rng;
  logic [1:0]        cfg_cs;
  logic [ADDR_W-1:0] cfg_start;
  logic [ADDR_W-1:0] cfg_end;
  logic              busy_q;

  logic take_go;
  logic load;
  logic fire;
  logic adv;
  logic plan_last;

  // configuration seen by the counters: live inputs in the go cycle
  logic [1:0]        src_mode;
  logic              src_down;
  logic              src_rng;
  logic [ADDR_W-1:0] src_start;
  logic [ADDR_W-1:0] src_end;

  logic [NUM_DIM-1:0] fin;
  logic [NUM_DIM-1:0] step;
  logic [NUM_DIM-1:0] inv;
  logic               bad_rng;
  logic [ADDR_W-1:0]  cur_addr;

  assign take_go = go_i & ~busy_q & ~restart_i;
  assign load    = take_go | restart_i;
  assign fire    = busy_q & addr_ready_i;
  assign adv     = fire & ~restart_i & ~plan_last;

  assign src_mode  = take_go ? mode_i       : cfg_mode;
  assign src_down  = take_go ? down_i       : cfg_down;
  assign src_rng   = take_go ? range_en_i   : cfg_rng;
  assign src_start = take_go ? start_addr_i : cfg_start;
  assign src_end   = take_go ? end_addr_i   : cfg_end;

  assign bad_rng = |inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode  <= '0;
      cfg_down  <= 1'b0;
      cfg_rng   <= 1'b0;
      cfg_cs    <= '0;
      cfg_start <= '0;
      cfg_end   <= '0;
    end else if (take_go) begin
      cfg_mode  <= mode_i;
      cfg_down  <= down_i;
      cfg_rng   <= range_en_i;
      cfg_cs    <= rank_sel_i;
      cfg_start <= start_addr_i;
      cfg_end   <= end_addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 busy_q <= 1'b0;
    else if (load)              busy_q <= 1'b1;
    else if (fire && plan_last) busy_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_DIM; g++) begin : g_dim
    localparam int DW  = (g == DIM_COL) ? COL_W : (g == DIM_ROW) ? ROW_W : BANK_W;
    localparam int OFS = (g == DIM_COL) ? 0 : (g == DIM_ROW) ? COL_W : COL_W + ROW_W;

    logic [DW-1:0] s_f;
    logic [DW-1:0] e_f;
    logic [DW-1:0] lo;
    logic [DW-1:0] hi;
    logic [DW-1:0] v;

    assign s_f    = src_start[OFS +: DW];
    assign e_f    = src_end[OFS +: DW];
    assign inv[g] = src_rng & (e_f < s_f);
    // an inverted box collapses every dimension onto the start field
    assign lo     = src_rng ? s_f : '0;
    assign hi     = bad_rng ? s_f : (src_rng ? e_f : '1);

    bist_dim_cnt #(.W(DW)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .step_i  (step[g]),
      .down_i  (src_down),
      .lo_i    (lo),
      .hi_i    (hi),
      .val_o   (v),
      .final_o (fin[g])
    );

    assign cur_addr[OFS +: DW] = v;
  end

  bist_step_plan plan_i (
    .mode_i (ord_e'(src_mode)),
    .adv_i  (adv),
    .fin_i  (fin),
    .step_o (step),
    .last_o (plan_last)
  );

  assign addr_valid_o = busy_q;
  assign addr_last_o  = busy_q & plan_last;
  assign addr_col_o   = cur_addr[COL_W-1:0];
  assign addr_row_o   = cur_addr[COL_W +: ROW_W];
  assign addr_bank_o  = cur_addr[COL_W+ROW_W +: BANK_W];
  assign rank_cs_o    = cfg_cs;
  assign busy_o       = busy_q;
endmodule

// File: rtl/bist_addr_seq_chk.sv
module bist_addr_seq_chk #(
  parameter int COL_W  = 3,
  parameter int ROW_W  = 2,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go_i,
  input logic              restart_i,
  input logic              addr_ready_i,
  input logic              addr_valid_o,
  input logic [BANK_W-1:0] addr_bank_o,
  input logic [ROW_W-1:0]  addr_row_o,
  input logic [COL_W-1:0]  addr_col_o,
  input logic              addr_last_o,
  input logic [1:0]        rank_cs_o,
  input logic              busy_o
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && go_i && !restart_i) |=> addr_valid_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i && !restart_i) |=>
      (addr_valid_o && $stable({addr_bank_o, addr_row_o, addr_col_o, addr_last_o})));

  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && addr_ready_i && addr_last_o && !restart_i) |=> !addr_valid_o);

  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && addr_ready_i && !addr_last_o && !restart_i) |=>
      (addr_valid_o && ({addr_bank_o, addr_row_o, addr_col_o} !=
                        $past({addr_bank_o, addr_row_o, addr_col_o}))));

  p_rank_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rank_cs_o));
endmodule

bind bist_addr_seq bist_addr_seq_chk #(
  .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W)
) chk_i (.*);

// File: tb/bist_addr_seq_tb_top.sv
`timescale 1ns/1ps
module bist_addr_seq_tb_top;
  typedef struct packed {
    logic [1:0] mode;
    logic       down;
    logic       rng;
    logic [1:0] cs;
    logic [6:0] sa;
    logic [6:0] ea;
  } vec_t;

  // {bank[6:5], row[4:3], col[2:0]}
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 1'b0, 2'b01, 7'b00_00_000, 7'b00_00_000},
    '{2'b01, 1'b0, 1'b0, 2'b10, 7'b00_00_000, 7'b00_00_000},
    '{2'b10, 1'b0, 1'b0, 2'b01, 7'b00_00_000, 7'b00_00_000},
    '{2'b11, 1'b0, 1'b0, 2'b10, 7'b00_00_000, 7'b00_00_000},
    '{2'b00, 1'b1, 1'b1, 2'b01, 7'b01_01_010, 7'b10_11_110},
    '{2'b01, 1'b0, 1'b1, 2'b10, 7'b00_01_001, 7'b11_10_100},
    '{2'b10, 1'b1, 1'b1, 2'b01, 7'b01_00_000, 7'b11_11_100},
    '{2'b11, 1'b1, 1'b0, 2'b10, 7'b00_00_000, 7'b00_00_000},
    '{2'b11, 1'b0, 1'b1, 2'b01, 7'b00_10_101, 7'b01_11_111}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go_i = 1'b0;
  logic       restart_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic       down_i = 1'b0;
  logic       range_en_i = 1'b0;
  logic [1:0] rank_sel_i = '0;
  logic [6:0] start_addr_i = '0;
  logic [6:0] end_addr_i = '0;
  logic       addr_ready_i = 1'b0;
  logic       addr_valid_o;
  logic [1:0] addr_bank_o;
  logic [1:0] addr_row_o;
  logic [2:0] addr_col_o;
  logic       addr_last_o;
  logic [1:0] rank_cs_o;
  logic       busy_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bist_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .restart_i(restart_i),
    .mode_i(mode_i), .down_i(down_i), .range_en_i(range_en_i),
    .rank_sel_i(rank_sel_i), .start_addr_i(start_addr_i), .end_addr_i(end_addr_i),
    .addr_ready_i(addr_ready_i), .addr_valid_o(addr_valid_o),
    .addr_bank_o(addr_bank_o), .addr_row_o(addr_row_o), .addr_col_o(addr_col_o),
    .addr_last_o(addr_last_o), .rank_cs_o(rank_cs_o), .busy_o(busy_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fld(logic [6:0] a, int d);
    if (d == 0) return int'(a[2:0]);
    if (d == 1) return int'(a[4:3]);
    return int'(a[6:5]);
  endfunction

  function automatic bit is_inv(vec_t v);
    bit r = 1'b0;
    for (int d = 0; d < 3; d++)
      if (v.rng && fld(v.ea, d) < fld(v.sa, d)) r = 1'b1;
    return r;
  endfunction

  function automatic int lo_of(vec_t v, int d);
    return v.rng ? fld(v.sa, d) : 0;
  endfunction

  function automatic int hi_of(vec_t v, int d);
    return v.rng ? fld(v.ea, d) : ((d == 0) ? 7 : 3);
  endfunction

  function automatic int sp(vec_t v, int d);
    return hi_of(v, d) - lo_of(v, d) + 1;
  endfunction

  function automatic int total_of(vec_t v);
    if (is_inv(v)) return 1;
    if (v.mode == 2'b10) return sp(v, 0) * sp(v, 2);
    return sp(v, 0) * sp(v, 1) * sp(v, 2);
  endfunction

  function automatic int dval(vec_t v, int d, int k);
    return v.down ? hi_of(v, d) - k : lo_of(v, d) + k;
  endfunction

  function automatic logic [6:0] exp_at(vec_t v, int n);
    int kc, kr, kb;
    int c, r, b;
    if (is_inv(v)) return v.sa;
    case (v.mode)
      2'b00: begin kc = n % sp(v,0); kr = (n / sp(v,0)) % sp(v,1); kb = n / (sp(v,0) * sp(v,1)); end
      2'b01: begin kr = n % sp(v,1); kc = (n / sp(v,1)) % sp(v,0); kb = n / (sp(v,1) * sp(v,0)); end
      2'b10: begin kc = n % sp(v,0); kr = n % sp(v,1); kb = n / sp(v,0); end
      default: begin kc = n % sp(v,0); kb = (n / sp(v,0)) % sp(v,2); kr = n / (sp(v,0) * sp(v,2)); end
    endcase
    c = dval(v, 0, kc); r = dval(v, 1, kr); b = dval(v, 2, kb);
    return {b[1:0], r[1:0], c[2:0]};
  endfunction

  function automatic string tag_of(vec_t v);
    string t;
    case (v.mode)
      2'b00: t = "R3";
      2'b01: t = "R4";
      2'b10: t = "R5";
      default: t = "R6";
    endcase
    if (v.down) t = {t, "/R7"};
    if (v.rng)  t = {t, "/R8"};
    return t;
  endfunction

  function automatic int cur_addr();
    return int'({addr_bank_o, addr_row_o, addr_col_o});
  endfunction

  task automatic apply_cfg(vec_t v);
    mode_i = v.mode; down_i = v.down; range_en_i = v.rng;
    rank_sel_i = v.cs; start_addr_i = v.sa; end_addr_i = v.ea;
  endtask

  task automatic launch(vec_t v);
    apply_cfg(v);
    go_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go_i = 1'b0;
    chk("R2 valid after go", int'(addr_valid_o), 1);
    chk("R2 first address", cur_addr(), int'(exp_at(v, 0)));
  endtask

  task automatic accept();
    addr_ready_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    addr_ready_i = 1'b0;
  endtask

  task automatic run_pass(vec_t v, int stall_mod);
    int tot;
    string t;
    tot = total_of(v);
    t = tag_of(v);
    launch(v);
    for (int n = 0; n < tot; n++) begin
      chk({t, " valid"}, int'(addr_valid_o), 1);
      chk({t, " address"}, cur_addr(), int'(exp_at(v, n)));
      chk("R9 last flag", int'(addr_last_o), int'(n == tot - 1));
      chk("R13 rank select", int'(rank_cs_o), int'(v.cs));
      if (stall_mod > 0 && (n % stall_mod) == 1) begin
        @(posedge clk);
        @(negedge clk);
        chk("R10 held address", cur_addr(), int'(exp_at(v, n)));
        chk("R10 held last", int'(addr_last_o), int'(n == tot - 1));
      end
      accept();
    end
    chk("R9 valid low after last", int'(addr_valid_o), 0);
    chk("R9 busy low after last", int'(busy_o), 0);
  endtask

  initial begin
    vec_t v;
    vec_t w;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(addr_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(addr_valid_o), 0);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 last after reset", int'(addr_last_o), 0);

    // table of configurations, one full pass each
    for (int i = 0; i < NV; i++) run_pass(VECS[i], (i % 3) + 2);

    // R12: inverted row bounds
    v = '{2'b00, 1'b1, 1'b1, 2'b01, 7'b01_10_101, 7'b10_01_111};
    launch(v);
    chk("R12 only start address", cur_addr(), int'(v.sa));
    chk("R12 last immediately", int'(addr_last_o), 1);
    accept();
    chk("R12 valid low after single beat", int'(addr_valid_o), 0);

    // R10 on the final beat
    v = '{2'b00, 1'b0, 1'b1, 2'b10, 7'b00_00_011, 7'b00_00_100};
    launch(v);
    accept();
    @(posedge clk);
    @(negedge clk);
    chk("R10 final beat held", cur_addr(), int'(exp_at(v, 1)));
    chk("R10 final last held", int'(addr_last_o), 1);
    accept();
    chk("R9 idle after final beat", int'(addr_valid_o), 0);

    // R11: restart mid-pass, then restart while idle
    v = VECS[0];
    launch(v);
    for (int n = 0; n < 5; n++) accept();
    chk("R11 before restart", cur_addr(), int'(exp_at(v, 5)));
    restart_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart_i = 1'b0;
    chk("R11 reloaded first", cur_addr(), int'(exp_at(v, 0)));
    chk("R11 still valid", int'(addr_valid_o), 1);
    accept();
    chk("R11 continues after reload", cur_addr(), int'(exp_at(v, 1)));
    addr_ready_i = 1'b1;
    for (int n = 0; n < 200 && addr_valid_o; n++) @(negedge clk);
    addr_ready_i = 1'b0;
    chk("R11 drained", int'(addr_valid_o), 0);
    restart_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart_i = 1'b0;
    chk("R11 idle restart valid", int'(addr_valid_o), 1);
    chk("R11 idle restart first", cur_addr(), int'(exp_at(v, 0)));
    addr_ready_i = 1'b1;
    for (int n = 0; n < 200 && addr_valid_o; n++) @(negedge clk);
    addr_ready_i = 1'b0;

    // R13: go and new configuration while busy are ignored
    v = VECS[5];
    w = '{2'b11, 1'b1, 1'b0, 2'b01, 7'b00_00_000, 7'b00_00_000};
    launch(v);
    accept();
    apply_cfg(w);
    go_i = 1'b1;
    accept();
    go_i = 1'b0;
    chk("R13 sequence unaffected by go", cur_addr(), int'(exp_at(v, 2)));
    chk("R13 rank unaffected by go", int'(rank_cs_o), int'(v.cs));
    accept();
    chk("R13 sequence unaffected later", cur_addr(), int'(exp_at(v, 3)));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule